// File: doc/BRIEF.md
# Configuration Word Access Bridge

This block serves configuration-space style requests against a single device whose registers live in a 32-bit word array held inside the block. A requester hands over a device/function number, a byte offset, an access size and, for writes, a data value. The bridge turns every request into a whole-word access. Reads extract the addressed byte or half-word and right-align it. Writes of 1 or 2 bytes are done as read-modify-write, so only the addressed lane changes. When finished, the bridge returns a status code and the read data.

The bridge can also correct a device that misbehaves when its first base address register is programmed with a real address. This feature is chosen by a static parameter. When it is on, a full-word write of anything other than all-ones to byte offset 0x10 does two things: it stores the intended value in a shadow register, and it places a fixed substitute constant in the array. A later full-word read of that offset returns the shadow value. An all-ones write, which is the usual sizing probe, clears the shadow and is stored unchanged.

Top module: `cfg_rmw_bridge`

## Requirements
- R1: `reqReady` is high only while the bridge is idle, and a request is taken on a clock edge where `reqValid` and `reqReady` are both high. `rspDone` is high for exactly one cycle, in the second cycle after the accepting edge. `reqReady` stays low from the accepting edge until `rspDone` has fallen.
- R2: After reset every array word reads as zero and the shadow is invalid.
- R3: A request with a non-zero device/function number completes with status 1 (device not found) and data 0, and it leaves the array unchanged.
- R4: A size other than 1, 2 or 4 completes with status 2 (bad register) and data 0, and it leaves the array unchanged. Every other request completes with status 0.
- R5: The word index is the byte offset with its two low bits cleared. A 4-byte read returns the whole word, and a 4-byte write replaces the whole word.
- R6: A 1-byte read returns word bits [8*k+7 : 8*k], where k is offset bits [1:0], zero-extended to 32 bits.
- R7: A 2-byte read returns word bits [31:16] when offset bit 1 is set and bits [15:0] otherwise, zero-extended to 32 bits.
- R8: A 1-byte write replaces only byte lane k (offset bits [1:0]) with data bits [7:0]. All other bits of the word keep their value.
- R9: A 2-byte write replaces only half-word lane (offset bit 1) with data bits [15:0]. All other bits of the word keep their value.
- R10: With the shadow enabled, a 4-byte write of a value other than 0xFFFFFFFF to offset 0x10 stores that value in the shadow, marks the shadow valid, and puts 0x0000FFFF in the array word.
- R11: A 4-byte write of 0xFFFFFFFF to offset 0x10 invalidates the shadow and stores 0xFFFFFFFF in the array.
- R12: While the shadow is valid, a 4-byte read of offset 0x10 returns the shadow value. Sub-word reads of that word return the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Bridge can take a request |
| reqDevFn | input | 8 | Device/function number; only 0 is served |
| reqOffset | input | 8 | Byte offset in the configuration window |
| reqSize | input | 3 | Access size in bytes (1, 2 or 4 are legal) |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqWData | input | 32 | Write data, right-aligned |
| rspDone | output | 1 | One-cycle completion pulse |
| rspData | output | 32 | Read data, right-aligned; 0 for writes and errors |
| rspStatus | output | 2 | 0 ok, 1 device not found, 2 bad register |

## Verification
The hardest case to reach is the one where the shadow and the array disagree. The array holds 0x0000FFFF while a full-word read must return a different value, and sub-word reads of the same word must still expose the substitute. The bench reaches this state by writing a real-looking base address to offset 0x10. It then reads the word at all three sizes. It then sends the all-ones sizing probe and checks that both views agree again. Rejected writes are confirmed by reading the target word back after each error response.

// File: rtl/cfg_rmw_pkg.sv
package cfg_rmw_pkg;
  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_NODEV  = 2'd1,
    ST_BADREG = 2'd2
  } cfgStatus_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_EXEC = 2'd1,
    PH_DONE = 2'd2
  } cfgPhase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch the incoming request
    logic commit;   // perform the word access and register the response
  } cfgStrobe_t;
endpackage

// File: rtl/cfg_rmw_ctrl.sv
module cfg_rmw_ctrl
  import cfg_rmw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       rspDone,
  output cfgStrobe_t strobe
);
  cfgPhase_e phase;
  cfgPhase_e phaseNext;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: if (reqValid) phaseNext = PH_EXEC;
      PH_EXEC: phaseNext = PH_DONE;
      PH_DONE: phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  assign reqReady       = (phase == PH_IDLE);
  assign rspDone        = (phase == PH_DONE);
  assign strobe.capture = reqValid && reqReady;
  assign strobe.commit  = (phase == PH_EXEC);

  // R1
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> !reqReady);
  // R1
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> rspDone);
  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> (!rspDone && reqReady));
endmodule

// File: rtl/cfg_rmw_dp.sv
module cfg_rmw_dp
  import cfg_rmw_pkg::*;
#(
  parameter int          WORDS      = 64,
  parameter int          DEVFN_W    = 8,
  parameter bit          SHADOW_EN  = 1'b1,
  parameter int          SHADOW_OFF = 16,
  parameter logic [31:0] SUB_VALUE  = 32'h0000_FFFF,
  localparam int         AW         = $clog2(WORDS),
  localparam int         OFF_W      = AW + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobe_t         strobe,
  input  logic [DEVFN_W-1:0] reqDevFn,
  input  logic [OFF_W-1:0]   reqOffset,
  input  logic [2:0]         reqSize,
  input  logic               reqWrite,
  input  logic [31:0]        reqWData,
  output logic [31:0]        rspData,
  output logic [1:0]         rspStatus
);
  logic [DEVFN_W-1:0] curDevFn;
  logic [OFF_W-1:0]   curOff;
  logic [2:0]         curSize;
  logic               curWrite;
  logic [31:0]        curWData;

  logic [31:0] mem [WORDS];

  logic [AW-1:0] wordIdx;
  logic [1:0]    lane;
  logic [4:0]    byteShift;
  logic [4:0]    halfShift;
  logic [31:0]   rdWord;
  logic [31:0]   byteMask;
  logic [31:0]   halfMask;
  logic [31:0]   mergedWord;
  logic [31:0]   readVal;
  logic          sizeOk;
  logic          accessOk;
  logic          doWrite;
  logic          shadowHit;
  logic          shadowValid;
  logic [31:0]   shadowVal;
  logic          isProbe;
  cfgStatus_e    status;

  // request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curDevFn <= '0;
      curOff   <= '0;
      curSize  <= '0;
      curWrite <= 1'b0;
      curWData <= '0;
    end else if (strobe.capture) begin
      curDevFn <= reqDevFn;
      curOff   <= reqOffset;
      curSize  <= reqSize;
      curWrite <= reqWrite;
      curWData <= reqWData;
    end
  end

  assign wordIdx   = curOff[OFF_W-1:2];
  assign lane      = curOff[1:0];
  assign byteShift = {lane, 3'b000};
  assign halfShift = {curOff[1], 4'b0000};
  assign rdWord    = mem[wordIdx];
  assign byteMask  = 32'h0000_00FF << byteShift;
  assign halfMask  = 32'h0000_FFFF << halfShift;
  assign sizeOk    = (curSize == 3'd1) || (curSize == 3'd2) || (curSize == 3'd4);
  assign isProbe   = (curWData == 32'hFFFF_FFFF);

  always_comb begin
    if (curDevFn != '0)  status = ST_NODEV;
    else if (!sizeOk)    status = ST_BADREG;
    else                 status = ST_OK;
  end

  assign accessOk = (status == ST_OK);
  assign doWrite  = strobe.commit && accessOk && curWrite;

  // shadow register variant
  generate
    if (SHADOW_EN) begin : g_shadow
      assign shadowHit = (curSize == 3'd4) && (curOff == OFF_W'(SHADOW_OFF));
      always_ff @(posedge clk) begin
        if (!rstN) begin
          shadowValid <= 1'b0;
          shadowVal   <= '0;
        end else if (doWrite && shadowHit) begin
          shadowValid <= !isProbe;
          if (!isProbe) shadowVal <= curWData;
        end
      end
    end else begin : g_noshadow
      assign shadowHit   = 1'b0;
      assign shadowValid = 1'b0;
      assign shadowVal   = '0;
    end
  endgenerate

  always_comb begin
    unique case (curSize)
      3'd1:    mergedWord = (rdWord & ~byteMask) | ((curWData & 32'h0000_00FF) << byteShift);
      3'd2:    mergedWord = (rdWord & ~halfMask) | ((curWData & 32'h0000_FFFF) << halfShift);
      default: mergedWord = (shadowHit && !isProbe) ? SUB_VALUE : curWData;
    endcase
  end

  always_comb begin
    unique case (curSize)
      3'd1:    readVal = (rdWord >> byteShift) & 32'h0000_00FF;
      3'd2:    readVal = (rdWord >> halfShift) & 32'h0000_FFFF;
      default: readVal = (shadowHit && shadowValid) ? shadowVal : rdWord;
    endcase
  end

  // register array
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (doWrite) begin
      mem[wordIdx] <= mergedWord;
    end
  end

  // response
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspData   <= '0;
      rspStatus <= ST_OK;
    end else if (strobe.commit) begin
      rspStatus <= status;
      rspData   <= (accessOk && !curWrite) ? readVal : 32'h0;
    end
  end

  // R3 R4
  reject_no_touch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !accessOk) |=> $stable(rdWord));
  // R8
  byte_merge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doWrite && curSize == 3'd1) |=> (((rdWord ^ $past(rdWord)) & ~$past(byteMask)) == 32'h0));
  // R9
  half_merge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doWrite && curSize == 3'd2) |=> (((rdWord ^ $past(rdWord)) & ~$past(halfMask)) == 32'h0));
  // R10
  shadow_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doWrite && shadowHit && !isProbe) |=> (shadowValid && rdWord == SUB_VALUE));
  // R11
  shadow_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doWrite && shadowHit && isProbe) |=> (!shadowValid && rdWord == 32'hFFFF_FFFF));
endmodule

// File: rtl/cfg_rmw_bridge.sv
module cfg_rmw_bridge
  import cfg_rmw_pkg::*;
#(
  parameter int          WORDS      = 64,
  parameter int          DEVFN_W    = 8,
  parameter bit          SHADOW_EN  = 1'b1,
  parameter int          SHADOW_OFF = 16,
  parameter logic [31:0] SUB_VALUE  = 32'h0000_FFFF,
  localparam int         OFF_W      = $clog2(WORDS) + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [DEVFN_W-1:0] reqDevFn,
  input  logic [OFF_W-1:0]   reqOffset,
  input  logic [2:0]         reqSize,
  input  logic               reqWrite,
  input  logic [31:0]        reqWData,
  output logic               rspDone,
  output logic [31:0]        rspData,
  output logic [1:0]         rspStatus
);
  cfgStrobe_t strobe;

  cfg_rmw_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .rspDone  (rspDone),
    .strobe   (strobe)
  );

  cfg_rmw_dp #(
    .WORDS      (WORDS),
    .DEVFN_W    (DEVFN_W),
    .SHADOW_EN  (SHADOW_EN),
    .SHADOW_OFF (SHADOW_OFF),
    .SUB_VALUE  (SUB_VALUE)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqDevFn  (reqDevFn),
    .reqOffset (reqOffset),
    .reqSize   (reqSize),
    .reqWrite  (reqWrite),
    .reqWData  (reqWData),
    .rspData   (rspData),
    .rspStatus (rspStatus)
  );
endmodule

// File: tb/test_cfg_rmw_bridge.sv
module test_cfg_rmw_bridge;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic        reqReady;
  logic [7:0]  reqDevFn;
  logic [7:0]  reqOffset;
  logic [2:0]  reqSize;
  logic        reqWrite;
  logic [31:0] reqWData;
  logic        rspDone;
  logic [31:0] rspData;
  logic [1:0]  rspStatus;

  int checks = 0;
  int errors = 0;

  logic [31:0] gotData;
  logic [1:0]  gotStatus;

  always #2 clk = ~clk;

  cfg_rmw_bridge i_cfg_rmw_bridge (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqDevFn(reqDevFn), .reqOffset(reqOffset), .reqSize(reqSize),
    .reqWrite(reqWrite), .reqWData(reqWData), .rspDone(rspDone),
    .rspData(rspData), .rspStatus(rspStatus)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one transaction; handshake timing checked on every call (R1)
  task automatic doReq(input logic [7:0] devFn, input logic [7:0] off, input logic [2:0] sz,
                       input logic wr, input logic [31:0] wd);
    logic hs;
    @(negedge clk);
    hs = reqReady && !rspDone;
    reqValid = 1'b1; reqDevFn = devFn; reqOffset = off; reqSize = sz;
    reqWrite = wr; reqWData = wd;
    @(negedge clk);
    reqValid = 1'b0;
    hs = hs && !reqReady && !rspDone;
    @(negedge clk);
    hs = hs && !reqReady && rspDone;
    gotData = rspData; gotStatus = rspStatus;
    @(negedge clk);
    hs = hs && reqReady && !rspDone;
    check("R1 handshake", {31'b0, hs}, 32'd1);
  endtask

  task automatic tReset();
    check("R1 ready after reset", {31'b0, reqReady}, 32'd1);
    check("R1 no done after reset", {31'b0, rspDone}, 32'd0);
    doReq(8'd0, 8'h3C, 3'd4, 1'b0, 32'h0);
    check("R2 word zero", gotData, 32'h0);
    doReq(8'd0, 8'h10, 3'd4, 1'b0, 32'h0);
    check("R2 shadow invalid", gotData, 32'h0);
    check("R4 ok status", {30'b0, gotStatus}, 32'd0);
  endtask

  task automatic tWord();
    doReq(8'd0, 8'h20, 3'd4, 1'b1, 32'h1122_3344);
    check("R4 write ok", {30'b0, gotStatus}, 32'd0);
    doReq(8'd0, 8'h23, 3'd4, 1'b0, 32'h0);
    check("R5 unaligned word read", gotData, 32'h1122_3344);
    doReq(8'd0, 8'h24, 3'd4, 1'b0, 32'h0);
    check("R5 neighbour untouched", gotData, 32'h0);
  endtask

  task automatic tByteRead();
    logic [31:0] exp [4] = '{32'h44, 32'h33, 32'h22, 32'h11};
    for (int k = 0; k < 4; k++) begin
      doReq(8'd0, 8'h20 + 8'(k), 3'd1, 1'b0, 32'h0);
      check("R6 byte read", gotData, exp[k]);
    end
  endtask

  task automatic tHalfRead();
    doReq(8'd0, 8'h20, 3'd2, 1'b0, 32'h0);
    check("R7 low half", gotData, 32'h3344);
    doReq(8'd0, 8'h23, 3'd2, 1'b0, 32'h0);
    check("R7 high half", gotData, 32'h1122);
  endtask

  task automatic tByteWrite();
    doReq(8'd0, 8'h21, 3'd1, 1'b1, 32'hDEAD_BEAA);
    doReq(8'd0, 8'h20, 3'd4, 1'b0, 32'h0);
    check("R8 byte merge", gotData, 32'h1122_AA44);
    doReq(8'd0, 8'h23, 3'd1, 1'b1, 32'h0000_0077);
    doReq(8'd0, 8'h20, 3'd4, 1'b0, 32'h0);
    check("R8 top byte merge", gotData, 32'h7722_AA44);
  endtask

  task automatic tHalfWrite();
    doReq(8'd0, 8'h22, 3'd2, 1'b1, 32'h1234_BEEF);
    doReq(8'd0, 8'h20, 3'd4, 1'b0, 32'h0);
    check("R9 high half merge", gotData, 32'hBEEF_AA44);
    doReq(8'd0, 8'h21, 3'd2, 1'b1, 32'h0000_5566);
    doReq(8'd0, 8'h20, 3'd4, 1'b0, 32'h0);
    check("R9 low half merge", gotData, 32'hBEEF_5566);
  endtask

  task automatic tBadSize();
    doReq(8'd0, 8'h20, 3'd3, 1'b1, 32'h0);
    check("R4 bad size status", {30'b0, gotStatus}, 32'd2);
    doReq(8'd0, 8'h20, 3'd0, 1'b0, 32'h0);
    check("R4 bad size read status", {30'b0, gotStatus}, 32'd2);
    check("R4 bad size data", gotData, 32'h0);
    doReq(8'd0, 8'h20, 3'd4, 1'b0, 32'h0);
    check("R4 array unchanged", gotData, 32'hBEEF_5566);
  endtask

  task automatic tBadDev();
    doReq(8'd3, 8'h20, 3'd4, 1'b1, 32'hCAFE_F00D);
    check("R3 nodev write status", {30'b0, gotStatus}, 32'd1);
    doReq(8'd1, 8'h20, 3'd4, 1'b0, 32'h0);
    check("R3 nodev read status", {30'b0, gotStatus}, 32'd1);
    check("R3 nodev data", gotData, 32'h0);
    doReq(8'd0, 8'h20, 3'd4, 1'b0, 32'h0);
    check("R3 array unchanged", gotData, 32'hBEEF_5566);
  endtask

  task automatic tShadow();
    doReq(8'd0, 8'h10, 3'd4, 1'b1, 32'h1234_5678);
    doReq(8'd0, 8'h10, 3'd4, 1'b0, 32'h0);
    check("R12 shadow word read", gotData, 32'h1234_5678);
    doReq(8'd0, 8'h10, 3'd2, 1'b0, 32'h0);
    check("R10 substitute low half", gotData, 32'h0000_FFFF);
    doReq(8'd0, 8'h12, 3'd2, 1'b0, 32'h0);
    check("R10 substitute high half", gotData, 32'h0);
    doReq(8'd0, 8'h11, 3'd1, 1'b0, 32'h0);
    check("R12 byte read sees array", gotData, 32'hFF);
    doReq(8'd0, 8'h10, 3'd2, 1'b1, 32'h0000_ABCD);
    doReq(8'd0, 8'h10, 3'd4, 1'b0, 32'h0);
    check("R12 shadow kept after half write", gotData, 32'h1234_5678);
    doReq(8'd0, 8'h12, 3'd1, 1'b0, 32'h0);
    check("R9 half write reaches array", gotData, 32'h0);
    doReq(8'd0, 8'h10, 3'd1, 1'b0, 32'h0);
    check("R9 half write low byte", gotData, 32'hCD);
  endtask

  task automatic tShadowClear();
    doReq(8'd0, 8'h10, 3'd4, 1'b1, 32'hFFFF_FFFF);
    doReq(8'd0, 8'h10, 3'd4, 1'b0, 32'h0);
    check("R11 probe written through", gotData, 32'hFFFF_FFFF);
    doReq(8'd0, 8'h13, 3'd1, 1'b0, 32'h0);
    check("R11 probe top byte", gotData, 32'hFF);
    doReq(8'd0, 8'h14, 3'd4, 1'b1, 32'h8000_0000);
    doReq(8'd0, 8'h14, 3'd4, 1'b0, 32'h0);
    check("R10 other offset not shadowed", gotData, 32'h8000_0000);
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqDevFn = '0; reqOffset = '0;
    reqSize = '0; reqWrite = 1'b0; reqWData = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    fork
      begin
        tReset();
        tWord();
        tByteRead();
        tHalfRead();
        tByteWrite();
        tHalfWrite();
        tBadSize();
        tBadDev();
        tShadow();
        tShadowClear();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule